// File: doc/BRIEF.md
# Six-stage pipeline stall and bubble controller

This block decides, every cycle, which stage registers of an in-order six-stage instruction pipeline move forward and where an empty slot is left behind. The stages run in a fixed order: fetch, decode, address calculation, operand fetch, execute and write-back. The controller keeps a shadow descriptor per stage: a valid bit, the source operand id and whether it is read, whether that read goes to memory, and the destination id and whether the write goes to memory. A new descriptor is offered on the input side. It enters the fetch slot when `in_ready` is high.

Two conflicts stop an instruction. The first is a single memory port that fetch, operand reads and result writes all share. The second is a read-after-write dependence between the instruction in operand fetch and an older instruction in execute or write-back. When a stage stalls, it and every younger stage hold. Older stages keep moving, and the stage just ahead of the stall receives a cleared-valid entry. A build parameter enables a path from the execute result to the operand input, and this path removes the stall for a dependence on the immediately preceding instruction.

Top module: `hzd_ctl`

## Requirements
- R1: Reset (synchronous, active high) clears every stage valid bit. After reset `in_ready` is 1 and `mem_grant` is 0 (no owner).
- R2: Independent instructions flow one stage per cycle without holds. An instruction accepted at a clock edge shows in the write-back slot (`stage_valid[5]`) at the fifth edge after it.
- R3: When stage k stalls, stages 0..k hold, stage k+1 receives an entry with valid cleared (`bubble_ins[k+1]`), and older stages advance.
- R4: The memory port has fixed priority. Write-back (`mem_grant`=3) wins over operand fetch (`mem_grant`=2), and both win over fetch (`mem_grant`=1). A valid fetch slot that loses holds for that cycle, and `in_ready` is 0.
- R5: If the write-back stage writes memory while operand fetch needs a memory read, operand fetch stalls for one cycle.
- R6: With the bypass disabled, a consumer directly behind its producer stalls two cycles in operand fetch. Its memory read happens only after those cycles.
- R7: With the bypass enabled, a consumer directly behind its producer does not stall. `byp_sel` is 1 for exactly that cycle, and no memory read is made for the operand.
- R8: A consumer two instructions behind its producer stalls one cycle in either mode. The bypass is taken only from the execute stage.
- R9: An entry with valid cleared never causes a dependence stall or a memory access, whatever id and flag fields it carries.
- R10: A dependence exists only when the consumer reads its source, the producer writes its destination, and the two ids are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new instruction descriptor is offered |
| in_rd | input | 1 | Instruction reads its source operand |
| in_src | input | ID_W | Source operand id |
| in_src_mem | input | 1 | Source read uses the shared memory port |
| in_wr | input | 1 | Instruction writes its destination |
| in_dst | input | ID_W | Destination operand id |
| in_dst_mem | input | 1 | Destination write uses the shared memory port |
| in_ready | output | 1 | Fetch slot advances and takes the offered descriptor |
| stage_valid | output | 6 | Valid bit per stage, bit 0 fetch to bit 5 write-back |
| stage_hold | output | 6 | Stage register keeps its content this cycle |
| bubble_ins | output | 6 | Stage register loads an entry with valid cleared |
| byp_sel | output | 1 | Operand input takes the execute result |
| mem_grant | output | 2 | Memory port owner: 0 none, 1 fetch, 2 operand fetch, 3 write-back |

## Verification
The bench runs directed instruction streams and counts operand-fetch holds, bubbles, blocked fetches, bypass selections and port grants. Back-to-back dependent pairs are run on two builds, one with the bypass and one without. This separates the two-cycle stall from the zero-cycle bypass and shows whether the memory read is skipped. Dependences at distance two show that the bypass taps only the execute stage. Memory-read and memory-write instructions in full streams separate the fetch-loses-once rule from the write-back-over-operand rule. Stale ids left in cleared slots, and a producer that writes nothing, confirm that only real dependences stall.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  parameter int ID_W      = 4;
  parameter int NUM_STAGE = 6;

  localparam int S_FI = 0;
  localparam int S_DI = 1;
  localparam int S_CO = 2;
  localparam int S_FO = 3;
  localparam int S_EI = 4;
  localparam int S_WO = 5;

  typedef enum logic [1:0] {
    GNT_NONE = 2'd0,
    GNT_FI   = 2'd1,
    GNT_FO   = 2'd2,
    GNT_WO   = 2'd3
  } mem_gnt_e;

  typedef struct packed {
    logic            valid;
    logic            rd;
    logic            src_mem;
    logic [ID_W-1:0] src;
    logic            wr;
    logic            dst_mem;
    logic [ID_W-1:0] dst;
  } hzd_ins_t;

  // read-after-write between a consumer and an older producer
  function automatic logic raw_dep(hzd_ins_t c, hzd_ins_t p);
    return c.valid && c.rd && p.valid && p.wr && (c.src == p.dst);
  endfunction

  function automatic logic reads_mem(hzd_ins_t e);
    return e.valid && e.rd && e.src_mem;
  endfunction

  function automatic logic writes_mem(hzd_ins_t e);
    return e.valid && e.wr && e.dst_mem;
  endfunction

endpackage

// File: rtl/hzd_dep_check.sv
module hzd_dep_check
  import hzd_pkg::*;
#(
  parameter bit BYPASS = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  hzd_ins_t fo_e,
  input  hzd_ins_t ei_e,
  input  hzd_ins_t wo_e,
  output logic     byp_hit,
  output logic     dep_stall
);

  logic hit_ei;
  logic hit_wo;

  assign hit_ei = raw_dep(fo_e, ei_e);
  assign hit_wo = raw_dep(fo_e, wo_e);

  generate
    if (BYPASS) begin : g_byp
      // newest producer in execute feeds forward; write-back producer still waits
      assign byp_hit   = hit_ei;
      assign dep_stall = hit_wo && !hit_ei;
    end else begin : g_nobyp
      assign byp_hit   = 1'b0;
      assign dep_stall = hit_ei || hit_wo;
    end
  endgenerate

  // R9: a consumer slot with valid cleared never stalls
  a_r9_bubble_no_dep: assert property (@(posedge clk) disable iff (rst)
    !fo_e.valid |-> !dep_stall && !byp_hit);

endmodule

// File: rtl/hzd_mem_arb.sv
module hzd_mem_arb
  import hzd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     fi_need,
  input  logic     fo_need,
  input  logic     wo_need,
  output logic     gnt_fi,
  output logic     gnt_fo,
  output logic     gnt_wo,
  output mem_gnt_e owner
);

  always_comb begin
    gnt_wo = wo_need;
    gnt_fo = fo_need && !wo_need;
    gnt_fi = fi_need && !fo_need && !wo_need;
    if (gnt_wo)      owner = GNT_WO;
    else if (gnt_fo) owner = GNT_FO;
    else if (gnt_fi) owner = GNT_FI;
    else             owner = GNT_NONE;
  end

  // R4: single port, at most one owner
  a_r4_one_owner: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_fi, gnt_fo, gnt_wo}));

  // R5: write-back write excludes operand read
  a_r5_wo_beats_fo: assert property (@(posedge clk) disable iff (rst)
    wo_need |-> !gnt_fo);

endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl #(
  parameter int NST = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NST-1:0] stall_req,
  output logic [NST-1:0] hold,
  output logic [NST-1:0] bubble
);

  logic [NST:0] above;   // above[i]: some stage >= i requests a stall
  assign above[NST] = 1'b0;

  generate
    for (genvar i = NST - 1; i >= 0; i--) begin : g_st
      assign above[i] = above[i+1] || stall_req[i];
      assign hold[i]  = above[i];
      if (i == 0) begin : g_first
        assign bubble[i] = 1'b0;
      end else begin : g_rest
        assign bubble[i] = above[i-1] && !above[i];
      end
      if (i > 0) begin : g_chk
        // R3: a held stage forces all younger stages to hold
        a_r3_hold_chain: assert property (@(posedge clk) disable iff (rst)
          hold[i] |-> hold[i-1]);
      end
    end
  endgenerate

endmodule

// File: rtl/hzd_ctl.sv
module hzd_ctl
  import hzd_pkg::*;
#(
  parameter bit BYPASS = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_rd,
  input  logic [ID_W-1:0] in_src,
  input  logic            in_src_mem,
  input  logic            in_wr,
  input  logic [ID_W-1:0] in_dst,
  input  logic            in_dst_mem,
  output logic            in_ready,
  output logic [5:0]      stage_valid,
  output logic [5:0]      stage_hold,
  output logic [5:0]      bubble_ins,
  output logic            byp_sel,
  output logic [1:0]      mem_grant
);

  localparam int NST = NUM_STAGE;

  hzd_ins_t st [NST];
  hzd_ins_t in_e;

  logic           byp_hit, dep_stall;
  logic           fo_mem_req, wo_mem_req, fi_mem_req;
  logic           fo_stall, fi_stall;
  logic           gnt_fi, gnt_fo, gnt_wo;
  mem_gnt_e       owner;
  logic [NST-1:0] stall_req, hold, bubble;

  assign in_e = '{valid: in_valid, rd: in_rd, src_mem: in_src_mem, src: in_src,
                  wr: in_wr, dst_mem: in_dst_mem, dst: in_dst};

  hzd_dep_check #(.BYPASS(BYPASS)) u_dep (
    .clk(clk), .rst(rst), .fo_e(st[S_FO]), .ei_e(st[S_EI]), .wo_e(st[S_WO]),
    .byp_hit(byp_hit), .dep_stall(dep_stall)
  );

  // memory demand per stage; a bypassed or dependence-stalled read does not touch memory
  assign wo_mem_req = writes_mem(st[S_WO]);
  assign fo_mem_req = reads_mem(st[S_FO]) && !byp_hit && !dep_stall;
  assign fo_stall   = st[S_FO].valid && (dep_stall || (fo_mem_req && wo_mem_req));
  assign fi_mem_req = st[S_FI].valid && !fo_stall;

  hzd_mem_arb u_arb (
    .clk(clk), .rst(rst), .fi_need(fi_mem_req), .fo_need(fo_mem_req),
    .wo_need(wo_mem_req), .gnt_fi(gnt_fi), .gnt_fo(gnt_fo), .gnt_wo(gnt_wo),
    .owner(owner)
  );

  assign fi_stall = fi_mem_req && !gnt_fi;

  always_comb begin
    stall_req       = '0;
    stall_req[S_FO] = fo_stall;
    stall_req[S_FI] = fi_stall;
  end

  hzd_stall_ctl #(.NST(NST)) u_stall (
    .clk(clk), .rst(rst), .stall_req(stall_req), .hold(hold), .bubble(bubble)
  );

  generate
    for (genvar i = 0; i < NST; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          st[i] <= '0;
        end else if (!hold[i]) begin
          if (i == 0) begin
            st[i] <= in_e;
          end else begin
            st[i]       <= st[i-1];
            st[i].valid <= st[i-1].valid && !bubble[i];
          end
        end
      end
      assign stage_valid[i] = st[i].valid;
    end
  endgenerate

  assign in_ready   = !hold[S_FI];
  assign stage_hold = hold;
  assign bubble_ins = bubble;
  assign byp_sel    = byp_hit;
  assign mem_grant  = owner;

  // R1: nothing valid right after reset
  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stage_valid == '0));

  // R3: an operand-fetch stall leaves a cleared slot in execute
  a_r3_fo_bubble: assert property (@(posedge clk) disable iff (rst)
    stage_hold[S_FO] && !stage_hold[S_EI] |=> !stage_valid[S_EI]);

  // R4: a valid fetch that lost the port does not accept input
  a_r4_fetch_loses: assert property (@(posedge clk) disable iff (rst)
    (stage_valid[S_FI] && owner != GNT_FI && owner != GNT_NONE) |-> !in_ready);

  // R6: a held operand-fetch slot keeps its descriptor
  a_r6_fo_kept: assert property (@(posedge clk) disable iff (rst)
    stage_hold[S_FO] |=> st[S_FO] == $past(st[S_FO]));

  // R7: a bypassed operand never holds operand fetch
  a_r7_byp_no_hold: assert property (@(posedge clk) disable iff (rst)
    byp_sel |-> !stage_hold[S_FO]);

  // R9: an empty write-back slot never owns the port
  a_r9_no_empty_wo: assert property (@(posedge clk) disable iff (rst)
    !stage_valid[S_WO] |-> owner != GNT_WO);

endmodule

// File: tb/hzd_ctl_tb.sv
module hzd_ctl_tb;
  import hzd_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic            iv [2], ird [2], ismem [2], iwr [2], idmem [2];
  logic [ID_W-1:0] isrc [2], idst [2];
  logic            rdy [2], byp [2];
  logic [5:0]      sv [2], sh [2], sb [2];
  logic [1:0]      gnt [2];

  hzd_ctl u_dut (
    .clk(clk), .rst(rst), .in_valid(iv[0]), .in_rd(ird[0]), .in_src(isrc[0]),
    .in_src_mem(ismem[0]), .in_wr(iwr[0]), .in_dst(idst[0]), .in_dst_mem(idmem[0]),
    .in_ready(rdy[0]), .stage_valid(sv[0]), .stage_hold(sh[0]), .bubble_ins(sb[0]),
    .byp_sel(byp[0]), .mem_grant(gnt[0])
  );

  hzd_ctl #(.BYPASS(1'b0)) u_dut_nb (
    .clk(clk), .rst(rst), .in_valid(iv[1]), .in_rd(ird[1]), .in_src(isrc[1]),
    .in_src_mem(ismem[1]), .in_wr(iwr[1]), .in_dst(idst[1]), .in_dst_mem(idmem[1]),
    .in_ready(rdy[1]), .stage_valid(sv[1]), .stage_hold(sh[1]), .bubble_ins(sb[1]),
    .byp_sel(byp[1]), .mem_grant(gnt[1])
  );

  int checks = 0, fails = 0, cyc = 0;
  int fo_hold [2], bub_ei [2], fblk [2], nbyp [2], g_fo [2], g_wo [2];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int s = 0; s < 2; s++) begin
        if (sh[s][S_FO])        fo_hold[s]++;
        if (sb[s][S_EI])        bub_ei[s]++;
        if (iv[s] && !rdy[s])   fblk[s]++;
        if (byp[s])             nbyp[s]++;
        if (gnt[s] == 2'd2)     g_fo[s]++;
        if (gnt[s] == 2'd3)     g_wo[s]++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    for (int s = 0; s < 2; s++) begin
      iv[s] = 0; ird[s] = 0; ismem[s] = 0; iwr[s] = 0; idmem[s] = 0;
      isrc[s] = '0; idst[s] = '0;
    end
  endtask

  task automatic restart();
    clear_inputs();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    for (int s = 0; s < 2; s++) begin
      fo_hold[s] = 0; bub_ei[s] = 0; fblk[s] = 0; nbyp[s] = 0; g_fo[s] = 0; g_wo[s] = 0;
    end
  endtask

  // offer one descriptor and wait until the fetch slot takes it
  task automatic issue(input int s, input logic rd, input int src, input logic smem,
                       input logic wr, input int dst, input logic dmem);
    logic taken;
    iv[s] = 1; ird[s] = rd; isrc[s] = src[ID_W-1:0]; ismem[s] = smem;
    iwr[s] = wr; idst[s] = dst[ID_W-1:0]; idmem[s] = dmem;
    taken = 0;
    while (!taken) begin
      @(negedge clk);
      taken = rdy[s];
      @(posedge clk);
      #1;
    end
    iv[s] = 0;
  endtask

  task automatic plain(input int s);
    issue(s, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic t_reset();
    restart();
    @(negedge clk);
    check("R1 stage_valid", int'(sv[0]), 0);
    check("R1 in_ready", int'(rdy[0]), 1);
    check("R1 mem_grant", int'(gnt[0]), 0);
  endtask

  task automatic t_latency();
    restart();
    plain(0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R2 wo empty at edge 4", int'(sv[0][5]), 0);
    @(posedge clk);
    @(negedge clk);
    check("R2 wo valid at edge 5", int'(sv[0][5]), 1);
    restart();
    repeat (8) plain(0);
    idle(10);
    check("R2 no fetch blocks", fblk[0], 0);
    check("R2 no fo holds", fo_hold[0], 0);
  endtask

  task automatic t_adjacent();
    for (int s = 0; s < 2; s++) begin
      restart();
      issue(s, 0, 0, 0, 1, 3, 0);
      issue(s, 1, 3, 1, 0, 0, 0);
      idle(12);
      if (s == 0) begin
        check("R7 bypass no stall", fo_hold[0], 0);
        check("R7 byp_sel one cycle", nbyp[0], 1);
        check("R7 no operand memory read", g_fo[0], 0);
      end else begin
        check("R6 two stall cycles", fo_hold[1], 2);
        check("R3 bubbles into execute", bub_ei[1], 2);
        check("R6 read after stall", g_fo[1], 1);
        check("R6 no bypass", nbyp[1], 0);
      end
    end
  endtask

  task automatic t_distance2();
    for (int s = 0; s < 2; s++) begin
      restart();
      issue(s, 0, 0, 0, 1, 5, 0);
      plain(s);
      issue(s, 1, 5, 0, 0, 0, 0);
      idle(12);
      check("R8 one stall at distance two", fo_hold[s], 1);
      check("R8 no bypass from write-back", nbyp[s], 0);
    end
  endtask

  task automatic t_fetch_vs_fo();
    restart();
    issue(0, 1, 9, 1, 0, 0, 0);
    repeat (4) plain(0);
    idle(10);
    check("R4 fetch blocked once by operand read", fblk[0], 1);
    check("R4 operand read granted", g_fo[0], 1);
    check("R4 no fo hold", fo_hold[0], 0);
  endtask

  task automatic t_fetch_vs_wo();
    restart();
    issue(0, 0, 0, 0, 1, 7, 1);
    repeat (6) plain(0);
    idle(10);
    check("R4 fetch blocked once by write-back", fblk[0], 1);
    check("R4 write-back granted", g_wo[0], 1);
  endtask

  task automatic t_wo_vs_fo();
    restart();
    issue(0, 0, 0, 0, 1, 7, 1);
    plain(0);
    issue(0, 1, 5, 1, 0, 0, 0);
    plain(0);
    plain(0);
    idle(10);
    check("R5 fo holds one cycle", fo_hold[0], 1);
    check("R5 write-back grant", g_wo[0], 1);
    check("R5 operand grant", g_fo[0], 1);
  endtask

  task automatic t_stale_bubbles();
    restart();
    issue(1, 0, 0, 0, 1, 3, 0);
    // cleared slots carrying a write of id 3 to memory
    iv[1] = 0; iwr[1] = 1; idst[1] = 3; idmem[1] = 1;
    idle(3);
    issue(1, 1, 3, 0, 0, 0, 0);
    idle(10);
    check("R9 stale slots cause no stall", fo_hold[1], 0);
    check("R9 stale slots take no port", g_wo[1], 0);
  endtask

  task automatic t_no_writer();
    restart();
    issue(1, 0, 0, 0, 0, 3, 0);
    issue(1, 1, 3, 0, 0, 0, 0);
    idle(10);
    check("R10 producer without write", fo_hold[1], 0);
    restart();
    issue(1, 0, 0, 0, 1, 4, 0);
    issue(1, 1, 3, 0, 0, 0, 0);
    idle(10);
    check("R10 different ids", fo_hold[1], 0);
  endtask

  initial begin
    clear_inputs();
    t_reset();
    t_latency();
    t_adjacent();
    t_distance2();
    t_fetch_vs_fo();
    t_fetch_vs_wo();
    t_wo_vs_fo();
    t_stale_bubbles();
    t_no_writer();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule